// File: doc/BRIEF.md
# Four-Channel Conversion Sequencer with Result Readback

This block is the digital controller of a four-channel converter whose channels are sampled together and then converted one after another. A convert-start edge freezes every sample input and captures a channel mask. The mask comes from one of two places, picked by a mode input: a small register that the host writes over a parallel strobe bus, or four select pins. The block then walks the selected channels in ascending order and spends a fixed number of conversion clocks on each. A busy flag covers the whole run, and an active-low end-of-conversion strobe marks each finished channel.

Each result goes into the next free slot of a result bank. The host reads the slots back through chip-select and read strobes. A read pointer moves forward on every completed read and returns to the first slot at the end of the run. A first-data flag shows when the pointer is at the first slot. Sample codes arrive on ports in place of an analog front end. A parameter picks the output coding: straight binary, or two's complement formed by inverting the MSB.

All inputs are assumed synchronous to the single conversion clock `clk`. Strobe edges are found by comparing each strobe with its value one clock earlier.

Top module: `conv_sequencer`

## Requirements
- R1: `busy` rises at the first clock edge that sees `conv_start` high after being low, and stays high for exactly CONV_CLKS (14) clocks per selected channel.
- R2: The channel mask is captured at the start edge. Changing `sel_pins`, `sw_mode` or the select register during a run does not change which channels that run converts.
- R3: All sample inputs are frozen at the start edge. Results hold the values sampled at that edge, not later values.
- R4: A rising edge of `wr_n` seen while `cs_n` is 0 and `rd_n` is 1 loads `db_in[3:0]` into the channel-select register. Bit 0 selects channel 1 and bit 3 selects channel 4.
- R5: With `sw_mode` = 0 the mask is taken from `sel_pins` (bit 0 = channel 1). With `sw_mode` = 1 it is taken from the channel-select register.
- R6: Selected channels convert in ascending order from channel 1 to channel 4, each taking 14 clocks. The k-th converted channel lands in result slot k.
- R7: `eoc_n` gives exactly one low pulse, one clock long, at the end of each channel conversion, with the last pulse in the clock where `busy` falls.
- R8: The read pointer returns to slot 1 at each start edge. It advances on each rising edge of `rd_n` taken with `cs_n` low, and wraps to slot 1 after the last converted slot. `first_data` is 1 exactly while the pointer is at slot 1.
- R9: `db_oe` is 1 only while `cs_n` and `rd_n` are both 0. At other times `db_out` is all zeros.
- R10: With TWOS_COMP = 1, `db_out` is the sample code with bit 11 inverted. With TWOS_COMP = 0 it is the sample code unchanged.
- R11: A convert-start edge that arrives while `busy` is high is ignored. The run keeps its length, and no new run follows it.
- R12: A start edge with an empty mask is ignored: `busy` stays low and `eoc_n` stays high.
- R13: A `wr_n` rising edge taken with `rd_n` low, or with `cs_n` high, leaves the channel-select register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | input | 1 | Convert start; its rising edge begins a run |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| db_in | input | 4 | Data bus bits used by register writes |
| db_out | output | 12 | Result word read back |
| db_oe | output | 1 | Output enable for the external data pad driver |
| sel_pins | input | 4 | Hardware channel mask, bit 0 = channel 1 |
| sw_mode | input | 1 | 0: mask from pins, 1: mask from register |
| samples | input | 48 | Four 12-bit straight-binary sample codes, channel 1 in bits 11:0 |
| busy | output | 1 | Conversion run in progress |
| eoc_n | output | 1 | One-clock low pulse per finished channel |
| first_data | output | 1 | Read pointer is at result slot 1 |

## Verification
Several properties are checked on every cycle. They cover how `busy` rises only from an accepted start, the bounded per-channel counter, and the one-clock width of each `eoc_n` pulse. They also check that the captured mask holds still for the whole run, that the pointer returns home after a start, that the pointer stays inside the converted range, and that the select register changes only after a legal write. The remaining behaviours can only be shown by the bench's scenarios. These are the exact run length for a given mask, the ascending result order, and the frozen sample values when inputs change during a run. They also include the ignored restart and empty mask, the blocked writes, and the two output codings.

// File: rtl/conv_seq_pkg.sv
// Package: shared types for the conversion sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package conv_seq_pkg;

    // Engine state: idle or working through a channel list.
    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_t;

endpackage

// File: rtl/conv_mask_select.sv
// Module: conv_mask_select
// Holds the host-written channel-select register and offers the live
// channel mask, chosen between that register and the select pins.
// Assumes cs_n, rd_n, wr_n and db_in are synchronous to clk; a write
// is taken on the clock that first sees wr_n high after it was low.
module conv_mask_select #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           rd_n,
    input  logic           wr_n,
    input  logic [NCH-1:0] db_in,
    input  logic [NCH-1:0] sel_pins,
    input  logic           sw_mode,
    output logic [NCH-1:0] mask_now
);

    logic           wr_q;
    logic [NCH-1:0] chsel_q;
    logic           wr_take;

    // Purpose: a write is accepted on wr_n rising with cs_n low and rd_n high.
    assign wr_take = wr_n && !wr_q && !cs_n && rd_n;

    // Purpose: remember the previous write strobe level for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b1;
        else        wr_q <= wr_n;
    end

    // Purpose: load the channel-select register on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)       chsel_q <= '0;
        else if (wr_take) chsel_q <= db_in;
    end

    // Purpose: pick the live mask source by mode.
    always_comb begin
        mask_now = sw_mode ? chsel_q : sel_pins;
    end

    // R13: the register only changes after a legal write edge.
    a_r13_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chsel_q) |-> $past(!cs_n && rd_n && !wr_q));

endmodule

// File: rtl/conv_engine.sv
// Module: conv_engine
// Finds the convert-start edge, freezes samples and mask, then steps
// through the selected channels in ascending order, CONV_CLKS clocks
// each. It produces busy, a one-clock low end-of-conversion pulse per
// channel, and a result write for each finished channel.
// Assumes conv_start is synchronous to clk. Samples are straight binary;
// TWOS_COMP=1 inverts the MSB to form two's complement.
module conv_engine
    import conv_seq_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int DW        = 12,
    parameter int CONV_CLKS = 14,
    parameter bit TWOS_COMP = 1'b1,
    localparam int CW       = $clog2(NCH),
    localparam int KW       = $clog2(CONV_CLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic [NCH-1:0]    mask_now,
    input  logic [NCH*DW-1:0] samples,
    output logic              busy,
    output logic              eoc_n,
    output logic              seq_start,
    output logic [CW:0]       seq_len,
    output logic              res_we,
    output logic [CW-1:0]     res_slot,
    output logic [DW-1:0]     res_data
);

    localparam logic [KW-1:0] LAST_CNT = KW'(CONV_CLKS - 1);

    eng_state_t     state_q;
    logic           start_q;
    logic [NCH-1:0] act_mask;
    logic [CW-1:0]  ch_q;
    logic [CW-1:0]  slot_q;
    logic [KW-1:0]  cnt_q;
    logic           eoc_n_q;
    logic [CW:0]    len_q;
    logic [DW-1:0]  fmt   [NCH];
    logic [DW-1:0]  hold  [NCH];
    logic           ch_done;
    logic           more_left;
    logic [CW-1:0]  next_ch;

    // Purpose: lowest set mask bit at or above a given index.
    function automatic logic [CW-1:0] lowest_from(input logic [NCH-1:0] m,
                                                  input int from);
        lowest_from = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i] && i >= from) lowest_from = CW'(i);
        end
    endfunction

    // Purpose: true when any mask bit at or above an index is set.
    function automatic logic any_from(input logic [NCH-1:0] m, input int from);
        any_from = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (m[i] && i >= from) any_from = 1'b1;
        end
    endfunction

    // Per-channel output coding chosen by parameter.
    for (genvar g = 0; g < NCH; g++) begin : g_fmt
        if (TWOS_COMP) begin : g_twos
            assign fmt[g] = samples[g*DW +: DW] ^ {1'b1, {(DW-1){1'b0}}};
        end else begin : g_bin
            assign fmt[g] = samples[g*DW +: DW];
        end
    end

    // Purpose: accept a start edge only when idle and the mask is not empty.
    assign seq_start = conv_start && !start_q && (state_q == ENG_IDLE)
                       && (|mask_now);

    // Purpose: decode end of the current channel and what follows it.
    assign ch_done   = (state_q == ENG_RUN) && (cnt_q == LAST_CNT);
    assign more_left = any_from(act_mask, int'(ch_q) + 1);
    assign next_ch   = lowest_from(act_mask, int'(ch_q) + 1);

    // Purpose: remember the previous convert-start level.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b1;
        else        start_q <= conv_start;
    end

    // Purpose: sequence state, channel, slot and clock counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ENG_IDLE;
            act_mask <= '0;
            ch_q     <= '0;
            slot_q   <= '0;
            cnt_q    <= '0;
            len_q    <= '0;
        end else if (seq_start) begin
            state_q  <= ENG_RUN;
            act_mask <= mask_now;
            ch_q     <= lowest_from(mask_now, 0);
            slot_q   <= '0;
            cnt_q    <= '0;
            len_q    <= (CW+1)'($countones(mask_now));
        end else if (ch_done) begin
            cnt_q <= '0;
            if (more_left) begin
                ch_q   <= next_ch;
                slot_q <= slot_q + 1'b1;
            end else begin
                state_q <= ENG_IDLE;
            end
        end else if (state_q == ENG_RUN) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: freeze every sample code at the accepted start edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) hold[i] <= '0;
        end else if (seq_start) begin
            for (int i = 0; i < NCH; i++) hold[i] <= fmt[i];
        end
    end

    // Purpose: one-clock low end-of-conversion pulse after each channel.
    always_ff @(posedge clk) begin
        if (!rst_n) eoc_n_q <= 1'b1;
        else        eoc_n_q <= !ch_done;
    end

    assign busy     = (state_q == ENG_RUN);
    assign eoc_n    = eoc_n_q;
    assign seq_len  = (CW+1)'($countones(mask_now));
    assign res_we   = ch_done;
    assign res_slot = slot_q;
    assign res_data = hold[ch_q];

    // R1: busy only rises after an accepted start edge.
    a_r1_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(seq_start));

    // R6: the per-channel counter never passes its last value.
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= LAST_CNT));

    // R7: each end-of-conversion pulse lasts one clock.
    a_r7_eoc_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_n |=> eoc_n);

    // R7: a pulse only follows a clock in which a run was active.
    a_r7_eoc_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_n) |-> $past(busy));

    // R2: the captured mask holds still through a run.
    a_r2_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(act_mask));

    // R6: the slot index stays inside the captured channel count.
    a_r6_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, slot_q} < len_q));

endmodule

// File: rtl/conv_readback.sv
// Module: conv_readback
// Stores results into a slot bank and returns them over the host read
// strobes, with a pointer that starts at slot 1 on each run, advances
// per completed read and wraps after the last converted slot.
// Assumes cs_n and rd_n are synchronous to clk; db_out is zero while
// db_oe is low so an external pad driver sees a clean value.
module conv_readback #(
    parameter int NCH = 4,
    parameter int DW  = 12,
    localparam int CW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          seq_start,
    input  logic [CW:0]   seq_len,
    input  logic          res_we,
    input  logic [CW-1:0] res_slot,
    input  logic [DW-1:0] res_data,
    output logic [DW-1:0] db_out,
    output logic          db_oe,
    output logic          first_data
);

    logic [DW-1:0] bank [NCH];
    logic [CW-1:0] ptr_q;
    logic [CW:0]   len_q;
    logic          rd_q;
    logic          rd_done;
    logic          at_end;

    // Purpose: a read completes on rd_n rising while selected.
    assign rd_done = rd_n && !rd_q && !cs_n;
    assign at_end  = ({1'b0, ptr_q} == (len_q - 1'b1));

    // Purpose: remember the previous read strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b1;
        else        rd_q <= rd_n;
    end

    // Purpose: write each finished result into its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) bank[i] <= '0;
        end else if (res_we) begin
            bank[res_slot] <= res_data;
        end
    end

    // Purpose: pointer home on a start, step and wrap on each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            len_q <= (CW+1)'(1);
        end else if (seq_start) begin
            ptr_q <= '0;
            len_q <= seq_len;
        end else if (rd_done) begin
            ptr_q <= at_end ? '0 : ptr_q + 1'b1;
        end
    end

    // Purpose: drive the bus only during a selected read.
    always_comb begin
        db_oe  = !cs_n && !rd_n;
        db_out = db_oe ? bank[ptr_q] : '0;
    end

    assign first_data = (ptr_q == '0);

    // R8: after an accepted start the pointer is back at slot 1.
    a_r8_home_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> first_data);

    // R8: the pointer stays inside the converted range.
    a_r8_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, ptr_q} < len_q));

endmodule

// File: rtl/conv_sequencer.sv
// Module: conv_sequencer (top)
// Ties together mask selection, the conversion engine and the result
// readback. One clock serves as both the system and conversion clock.
// Assumes every input is synchronous to clk.
module conv_sequencer #(
    parameter int NCH       = 4,
    parameter int DW        = 12,
    parameter int CONV_CLKS = 14,
    parameter bit TWOS_COMP = 1'b1,
    localparam int CW       = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [NCH-1:0]    db_in,
    output logic [DW-1:0]     db_out,
    output logic              db_oe,
    input  logic [NCH-1:0]    sel_pins,
    input  logic              sw_mode,
    input  logic [NCH*DW-1:0] samples,
    output logic              busy,
    output logic              eoc_n,
    output logic              first_data
);

    logic [NCH-1:0] mask_now;
    logic           seq_start;
    logic [CW:0]    seq_len;
    logic           res_we;
    logic [CW-1:0]  res_slot;
    logic [DW-1:0]  res_data;

    conv_mask_select #(.NCH(NCH)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .db_in    (db_in),
        .sel_pins (sel_pins),
        .sw_mode  (sw_mode),
        .mask_now (mask_now)
    );

    conv_engine #(
        .NCH       (NCH),
        .DW        (DW),
        .CONV_CLKS (CONV_CLKS),
        .TWOS_COMP (TWOS_COMP)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .mask_now   (mask_now),
        .samples    (samples),
        .busy       (busy),
        .eoc_n      (eoc_n),
        .seq_start  (seq_start),
        .seq_len    (seq_len),
        .res_we     (res_we),
        .res_slot   (res_slot),
        .res_data   (res_data)
    );

    conv_readback #(.NCH(NCH), .DW(DW)) u_readback (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .seq_start  (seq_start),
        .seq_len    (seq_len),
        .res_we     (res_we),
        .res_slot   (res_slot),
        .res_data   (res_data),
        .db_out     (db_out),
        .db_oe      (db_oe),
        .first_data (first_data)
    );

endmodule

// File: tb/test_conv_sequencer.sv
// Directed bench for conv_sequencer: one task per scenario.
module test_conv_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_start = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [3:0]  db_in = 4'h0;
    logic [3:0]  sel_pins = 4'h0;
    logic        sw_mode = 1'b0;
    logic [11:0] s [4];
    logic [47:0] samples;
    logic [11:0] db_out, db_out_sb;
    logic        db_oe, db_oe_sb, busy, busy_sb, eoc_n, eoc_n_sb;
    logic        first_data, first_data_sb;
    int          n_checks = 0;
    int          n_fail = 0;

    assign samples = {s[3], s[2], s[1], s[0]};

    always #2 clk = ~clk;

    conv_sequencer i_conv_sequencer (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cs_n(cs_n),
        .rd_n(rd_n), .wr_n(wr_n), .db_in(db_in), .db_out(db_out),
        .db_oe(db_oe), .sel_pins(sel_pins), .sw_mode(sw_mode),
        .samples(samples), .busy(busy), .eoc_n(eoc_n),
        .first_data(first_data)
    );

    conv_sequencer #(.TWOS_COMP(1'b0)) i_conv_sequencer_sb (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cs_n(cs_n),
        .rd_n(rd_n), .wr_n(wr_n), .db_in(db_in), .db_out(db_out_sb),
        .db_oe(db_oe_sb), .sel_pins(sel_pins), .sw_mode(sw_mode),
        .samples(samples), .busy(busy_sb), .eoc_n(eoc_n_sb),
        .first_data(first_data_sb)
    );

    task automatic check(input logic ok, input string req,
                         input int actual, input int expected);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
        end
    endtask

    task automatic set_samples(input logic [11:0] a, input logic [11:0] b,
                               input logic [11:0] c, input logic [11:0] d);
        s[0] = a; s[1] = b; s[2] = c; s[3] = d;
    endtask

    // Runs a conversion; counts busy clocks and eoc_n low clocks.
    // With disturb set, inputs are changed and start is re-raised mid-run.
    task automatic run_conv(input bit disturb, output int cycles, output int eocs);
        @(negedge clk) conv_start = 1'b1;
        @(posedge clk) #1;
        cycles = 0;
        eocs = 0;
        while (busy && cycles < 200) begin
            @(posedge clk) #1;
            cycles++;
            if (!eoc_n) eocs++;
            if (disturb && cycles == 3) begin
                conv_start = 1'b0;
                sel_pins = ~sel_pins;
                sw_mode = ~sw_mode;
                set_samples(12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF);
            end
            if (disturb && cycles == 6) conv_start = 1'b1;
        end
        @(negedge clk) conv_start = 1'b0;
    endtask

    // One read cycle: samples bus and first_data while the strobe is low.
    task automatic read_word(output logic [11:0] d, output logic [11:0] d_sb,
                             output logic oe, output logic fd);
        @(negedge clk) begin cs_n = 1'b0; rd_n = 1'b0; end
        #1;
        d = db_out; d_sb = db_out_sb; oe = db_oe; fd = first_data;
        @(negedge clk) rd_n = 1'b1;
        @(negedge clk) cs_n = 1'b1;
    endtask

    task automatic bus_write(input logic [3:0] v, input logic cs_v, input logic rd_v);
        @(negedge clk) begin cs_n = cs_v; rd_n = rd_v; wr_n = 1'b0; db_in = v; end
        @(negedge clk) wr_n = 1'b1;
        @(negedge clk) begin cs_n = 1'b1; rd_n = 1'b1; db_in = 4'h0; end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        check(eoc_n == 1'b1, "R7 reset eoc_n", eoc_n, 1);
        check(first_data == 1'b1, "R8 reset first_data", first_data, 1);
        check(db_oe == 1'b0 && db_out == 12'h0, "R9 reset bus", db_oe, 0);
    endtask

    // Pins select channels 2 and 4.
    task automatic t_hw_order;
        int cyc, eo;
        logic [11:0] d, dsb;
        logic oe, fd;
        sw_mode = 1'b0;
        sel_pins = 4'b1010;
        set_samples(12'h111, 12'h222, 12'h933, 12'h0A4);
        run_conv(1'b0, cyc, eo);
        check(cyc == 28, "R1 busy length two channels", cyc, 28);
        check(eo == 2, "R7 eoc pulse count", eo, 2);
        read_word(d, dsb, oe, fd);
        check(d == (12'h222 ^ 12'h800), "R6 R10 slot1 is ch2 twos", d, 12'h222 ^ 12'h800);
        check(dsb == 12'h222, "R10 slot1 straight", dsb, 12'h222);
        check(oe == 1'b1, "R9 oe during read", oe, 1);
        check(fd == 1'b1, "R8 first_data at slot1", fd, 1);
        read_word(d, dsb, oe, fd);
        check(d == (12'h0A4 ^ 12'h800), "R6 slot2 is ch4", d, 12'h0A4 ^ 12'h800);
        check(fd == 1'b0, "R8 first_data off at slot2", fd, 0);
        read_word(d, dsb, oe, fd);
        check(d == (12'h222 ^ 12'h800) && fd, "R8 pointer wraps", d, 12'h222 ^ 12'h800);
    endtask

    // Register selects channels 1, 3, 4; pins select only channel 1.
    task automatic t_sw_mode;
        int cyc, eo;
        logic [11:0] d, dsb;
        logic oe, fd;
        bus_write(4'b1101, 1'b0, 1'b1);
        sw_mode = 1'b1;
        sel_pins = 4'b0001;
        set_samples(12'h101, 12'h202, 12'h303, 12'h404);
        run_conv(1'b0, cyc, eo);
        check(cyc == 42, "R4 R5 register mask three channels", cyc, 42);
        check(eo == 3, "R7 three eoc pulses", eo, 3);
        read_word(d, dsb, oe, fd);
        check(dsb == 12'h101, "R6 slot1 ch1", dsb, 12'h101);
        read_word(d, dsb, oe, fd);
        check(dsb == 12'h303, "R6 slot2 ch3", dsb, 12'h303);
        read_word(d, dsb, oe, fd);
        check(dsb == 12'h404, "R6 slot3 ch4", dsb, 12'h404);
    endtask

    // Writes with rd_n low or cs_n high must not replace the 1101 mask.
    task automatic t_blocked_write;
        int cyc, eo;
        bus_write(4'b0010, 1'b0, 1'b0);
        bus_write(4'b0010, 1'b1, 1'b1);
        sw_mode = 1'b1;
        run_conv(1'b0, cyc, eo);
        check(cyc == 42, "R13 blocked writes ignored", cyc, 42);
    endtask

    // Inputs change and start re-rises during the run.
    task automatic t_disturb;
        int cyc, eo;
        logic [11:0] d, dsb;
        logic oe, fd;
        sw_mode = 1'b0;
        sel_pins = 4'b0110;
        set_samples(12'h010, 12'h020, 12'h030, 12'h040);
        run_conv(1'b1, cyc, eo);
        check(cyc == 28, "R2 R11 run length kept", cyc, 28);
        check(eo == 2, "R2 eoc count kept", eo, 2);
        repeat (5) begin
            @(posedge clk) #1;
            check(busy == 1'b0, "R11 no restart after run", busy, 0);
        end
        read_word(d, dsb, oe, fd);
        check(dsb == 12'h020, "R3 ch2 frozen sample", dsb, 12'h020);
        read_word(d, dsb, oe, fd);
        check(dsb == 12'h030, "R3 ch3 frozen sample", dsb, 12'h030);
        sw_mode = 1'b0;
    endtask

    task automatic t_empty;
        sw_mode = 1'b0;
        sel_pins = 4'b0000;
        @(negedge clk) conv_start = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk) #1;
            check(busy == 1'b0 && eoc_n == 1'b1, "R12 empty mask ignored", busy, 0);
        end
        @(negedge clk) conv_start = 1'b0;
    endtask

    task automatic t_bus_idle;
        @(negedge clk) begin cs_n = 1'b0; rd_n = 1'b1; end
        #1 check(db_oe == 1'b0 && db_out == 12'h0, "R9 no drive rd high", db_oe, 0);
        @(negedge clk) begin cs_n = 1'b1; rd_n = 1'b0; end
        #1 check(db_oe == 1'b0 && db_out == 12'h0, "R9 no drive cs high", db_oe, 0);
        @(negedge clk) rd_n = 1'b1;
    endtask

    initial begin
        set_samples(12'h0, 12'h0, 12'h0, 12'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hw_order();
        t_sw_mode();
        t_blocked_write();
        t_disturb();
        t_empty();
        t_bus_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule